// File: doc/BRIEF.md
# Two-Context Mode Controller and Shared-Port Arbiter

This block sits in a core that carries two hardware thread contexts over one set of shared structures. It keeps track of which contexts are running and reports the operating mode. Four modes exist: both contexts running, only context 0 running, only context 1 running, or neither running. A halt pulse stops a running context. An interrupt pulse restarts a halted one. Mode changes take effect on the clock edge that follows the event.

In the same cycle, the block decides which context may use one shared resource, such as an instruction fetch port or a microcode sequencer. The grant is combinational from the request lines and the registered running state, so a lone requester is served in the cycle it asks. When both contexts contend, a one-bit priority pointer alternates the winner. The grant comes with a context tag so that downstream shared state can keep per-context entries apart. A halted context cannot take any share of the resource, so the running context gets all of it.

Top module: `dual_ctx_sched`

## Requirements
- R1: After a synchronous active-low reset, both contexts are running (mode 2'b00) and the priority pointer favours context 0, so a first contended cycle grants context 0.
- R2: Mode encoding is 2'b00 both running, 2'b01 only context 0 running, 2'b10 only context 1 running, 2'b11 none running. A halt pulse (halt[i]=1) on a running context makes it stopped from the next cycle on. When both run and both halt, the mode becomes 2'b11.
- R3: An interrupt pulse (intr[i]=1) to a stopped context makes it running from the next cycle on. From mode 2'b11 this gives the single-context mode of the interrupted context, or 2'b00 if both are interrupted. An interrupt to a running context and a halt to a stopped context have no effect.
- R4: The grant vector (bit i for context i) has at most one bit set in any cycle.
- R5: tag_id is 1 when context 1 holds the grant and 0 otherwise.
- R6: While both run, a single requesting context is granted in the same cycle it requests.
- R7: When both running contexts request, the context named by the priority pointer wins. After every grant the pointer moves to the context that was not granted.
- R8: In a single-context mode only the running context can be granted. Requests from the stopped context produce no grant.
- R9: In mode 2'b11 no grant is issued.
- R10: Whenever at least one running context requests, a grant is issued in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 2 | Per-context request for the shared resource |
| halt | input | 2 | Per-context halt pulse |
| intr | input | 2 | Per-context interrupt pulse |
| mode | output | 2 | Current operating mode (encoding in R2) |
| grant | output | 2 | One-hot grant, bit i for context i |
| tag_id | output | 1 | Context tag of the granted access |

## Verification
A vector table drives request patterns with no requester, one requester and both requesters, in every mode. The lone-requester cycles separate the same-cycle grant from the alternation. The contended cycles show that the pointer moves after single grants as well as after ties. Halt and interrupt pulses are applied singly, together on both contexts, and crossed (one context halts while the other wakes). Pulses that must have no effect are included: an interrupt to a running context and a halt to a stopped one. The following grant and mode reveal whether the running state changed. Directed tests then reset from the idle mode and run a long contended stretch.

// File: rtl/dual_ctx_pkg.sv
// Shared definitions for the two-context scheduler.
// Assumes exactly two contexts; the mode encoding depends on that.
package dual_ctx_pkg;
    localparam int NUM_CTX = 2;
    localparam int ID_W    = 1;

    typedef enum logic [1:0] {
        MODE_BOTH  = 2'b00,
        MODE_ONLY0 = 2'b01,
        MODE_ONLY1 = 2'b10,
        MODE_NONE  = 2'b11
    } mode_e;
endpackage

// File: rtl/ctx_mode_fsm.sv
// Running-state tracker: one "running" flag per context, cleared by halt,
// set by interrupt. The mode is decoded from the flags.
// Assumes halt/intr are single-cycle pulses sampled on clk.
module ctx_mode_fsm
    import dual_ctx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTX-1:0] halt,
    input  logic [NUM_CTX-1:0] intr,
    output logic [NUM_CTX-1:0] running,
    output mode_e              mode
);
    logic [NUM_CTX-1:0] run_q;

    // Per-context running flag: halt stops a running context, intr wakes a stopped one.
    for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
        always_ff @(posedge clk) begin
            if (!rst_n)
                run_q[i] <= 1'b1;
            else if (run_q[i])
                run_q[i] <= ~halt[i];
            else
                run_q[i] <= intr[i];
        end
    end

    // Decode the running flags into the reported mode.
    always_comb begin
        unique case (run_q)
            2'b11:   mode = MODE_BOTH;
            2'b01:   mode = MODE_ONLY0;
            2'b10:   mode = MODE_ONLY1;
            default: mode = MODE_NONE;
        endcase
    end

    assign running = run_q;

    // R2: a lone halt while both run leaves the other context alone.
    assert_halt0_from_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BOTH && halt == 2'b01) |=> (mode == MODE_ONLY1));
    assert_halt1_from_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BOTH && halt == 2'b10) |=> (mode == MODE_ONLY0));
    // R3: the idle mode is left only through an interrupt.
    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NONE && intr == 2'b00) |=> (mode == MODE_NONE));
    // R3: an interrupt to the stopped context restores both-running mode.
    assert_wake_to_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ONLY0 && intr[1] && !halt[0]) |=> (mode == MODE_BOTH));
endmodule

// File: rtl/ctx_rr_arb.sv
// Two-way arbiter for one shared resource. Only running contexts are
// eligible. A tie goes to the context named by the priority pointer, and the
// pointer moves to the losing side after every grant.
// Assumes `running` is a registered signal (grant path is combinational).
module ctx_rr_arb
    import dual_ctx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTX-1:0] req,
    input  logic [NUM_CTX-1:0] running,
    output logic [NUM_CTX-1:0] grant,
    output logic [ID_W-1:0]    tag_id
);
    logic [NUM_CTX-1:0] elig;
    logic               prio_q;
    logic               prev_tie_q;
    logic [NUM_CTX-1:0] prev_grant_q;

    assign elig = req & running;

    // Pick the winner among eligible requesters.
    always_comb begin
        unique case (elig)
            2'b01:   grant = 2'b01;
            2'b10:   grant = 2'b10;
            2'b11:   grant = prio_q ? 2'b10 : 2'b01;
            default: grant = 2'b00;
        endcase
    end

    assign tag_id = grant[1];

    // Move the priority pointer to the context that did not win.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prio_q <= 1'b0;
        else if (|grant)
            prio_q <= grant[0];
    end

    // History of the previous cycle, kept only for the alternation check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_tie_q   <= 1'b0;
            prev_grant_q <= '0;
        end else begin
            prev_tie_q   <= (elig == 2'b11);
            prev_grant_q <= grant;
        end
    end

    // R4: never more than one context holds the resource.
    assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R5: the tag names the granted context.
    assert_tag_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> grant[tag_id]);
    // R7: back-to-back ties alternate the winner.
    assert_tie_alternates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == 2'b11 && prev_tie_q) |-> (grant != prev_grant_q));
endmodule

// File: rtl/dual_ctx_sched.sv
// Top level: running-state tracker feeding the shared-resource arbiter.
// Mode changes appear one cycle after the pulse; grants follow requests in
// the same cycle.
module dual_ctx_sched
    import dual_ctx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  req,
    input  logic [1:0]  halt,
    input  logic [1:0]  intr,
    output logic [1:0]  mode,
    output logic [1:0]  grant,
    output logic        tag_id
);
    logic [NUM_CTX-1:0] running;
    mode_e              mode_w;

    ctx_mode_fsm u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .halt    (halt),
        .intr    (intr),
        .running (running),
        .mode    (mode_w)
    );

    ctx_rr_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .running (running),
        .grant   (grant),
        .tag_id  (tag_id)
    );

    assign mode = mode_w;

    // R10: a running requester always gets the resource this cycle.
    assert_progress_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req & running)) |-> (|grant));
    // R8: a stopped context is never granted.
    assert_no_stopped_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~running) == 2'b00);
    // R9: idle mode issues no grant.
    assert_idle_no_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == MODE_NONE) |-> (grant == 2'b00));
endmodule

// File: tb/dual_ctx_sched_test.sv
// Bench: table walk of {req, halt, intr, exp_mode, exp_grant}, then directed tests.
module dual_ctx_sched_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] req = '0, halt = '0, intr = '0;
    logic [1:0] mode, grant;
    logic       tag_id;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    dual_ctx_sched uut (
        .clk(clk), .rst_n(rst_n), .req(req), .halt(halt), .intr(intr),
        .mode(mode), .grant(grant), .tag_id(tag_id)
    );

    localparam int NVEC = 25;
    // Fields: req[9:8] halt[7:6] intr[5:4] mode[3:2] grant[1:0]
    localparam logic [9:0] VEC [NVEC] = '{
        {2'b11, 2'b00, 2'b00, 2'b00, 2'b01},
        {2'b11, 2'b00, 2'b00, 2'b00, 2'b10},
        {2'b10, 2'b00, 2'b00, 2'b00, 2'b10},
        {2'b11, 2'b00, 2'b00, 2'b00, 2'b01},
        {2'b01, 2'b00, 2'b00, 2'b00, 2'b01},
        {2'b11, 2'b00, 2'b00, 2'b00, 2'b10},
        {2'b00, 2'b01, 2'b00, 2'b00, 2'b00},
        {2'b11, 2'b00, 2'b00, 2'b10, 2'b10},
        {2'b01, 2'b00, 2'b00, 2'b10, 2'b00},
        {2'b00, 2'b01, 2'b10, 2'b10, 2'b00},
        {2'b00, 2'b00, 2'b01, 2'b10, 2'b00},
        {2'b11, 2'b00, 2'b00, 2'b00, 2'b01},
        {2'b00, 2'b10, 2'b00, 2'b00, 2'b00},
        {2'b11, 2'b00, 2'b00, 2'b01, 2'b01},
        {2'b10, 2'b01, 2'b00, 2'b01, 2'b00},
        {2'b11, 2'b00, 2'b00, 2'b11, 2'b00},
        {2'b00, 2'b00, 2'b10, 2'b11, 2'b00},
        {2'b11, 2'b00, 2'b00, 2'b10, 2'b10},
        {2'b00, 2'b10, 2'b01, 2'b10, 2'b00},
        {2'b11, 2'b00, 2'b00, 2'b01, 2'b01},
        {2'b00, 2'b01, 2'b00, 2'b01, 2'b00},
        {2'b00, 2'b00, 2'b11, 2'b11, 2'b00},
        {2'b11, 2'b00, 2'b00, 2'b00, 2'b10},
        {2'b11, 2'b11, 2'b00, 2'b00, 2'b01},
        {2'b11, 2'b00, 2'b00, 2'b11, 2'b00}
    };

    task automatic check(input string what, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    // Checks shared by every sampled cycle: R4 one-hot and R5 tag.
    task automatic check_common(input logic [1:0] exp_grant);
        check("R4 grant one-hot", {1'b0, $onehot0(grant)}, 2'b01);
        check("R5 tag_id", {1'b0, tag_id}, {1'b0, exp_grant[1]});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // Table walk covering R2, R3, R6, R7, R8, R9, R10.
        for (int k = 0; k < NVEC; k++) begin
            req  = VEC[k][9:8];
            halt = VEC[k][7:6];
            intr = VEC[k][5:4];
            #1;
            check("R2/R3 mode", mode, VEC[k][3:2]);
            check("R6/R7/R8/R9/R10 grant", grant, VEC[k][1:0]);
            check_common(VEC[k][1:0]);
            @(negedge clk);
        end

        // R1: reset from idle mode (pointer was at context 1).
        req = 2'b11; halt = 2'b00; intr = 2'b00; rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R1 mode after reset", mode, 2'b00);
        check("R1 first contended grant", grant, 2'b01);
        @(negedge clk);

        // R7: long contention alternates, starting with context 1.
        for (int i = 0; i < 6; i++) begin
            #1;
            check("R7 alternation", grant, (i % 2 == 0) ? 2'b10 : 2'b01);
            check_common((i % 2 == 0) ? 2'b10 : 2'b01);
            @(negedge clk);
        end

        // R8: halt context 1, then its requests are ignored for several cycles.
        req = 2'b00; halt = 2'b10;
        @(negedge clk);
        halt = 2'b00; req = 2'b10;
        for (int i = 0; i < 4; i++) begin
            #1;
            check("R8 mode only0", mode, 2'b01);
            check("R8 stopped request ignored", grant, 2'b00);
            @(negedge clk);
        end
        // R10: running context served immediately alongside the ignored one.
        req = 2'b11;
        #1;
        check("R10 running requester served", grant, 2'b01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule